// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for IEEE 802.3 Clause 22 management frames on an MDC/MDIO pin pair. Software works through six 32-bit word registers on a simple write-strobe bus with a combinational read port. It holds the target PHY and register number in one register. It starts a write by storing 16 data bits, and it starts a read by raising a command bit. It then polls an indication register until the frame has left the wire.

MDC is derived from the system clock by a free-running divider whose rate comes from a 3-bit configuration code. A frame begins on the first falling MDC edge after the command. MDIO changes only on falling MDC edges and is sampled on rising ones. The output enable is removed whenever the master is not driving. A configuration bit aborts a frame in progress.

Top module: `mdio_master`

## Requirements
- R1: Register word index 2 (address) stores the PHY address in bits [12:8] and the register number in bits [4:0]; every other bit reads back as 0.
- R2: Writing word index 3 (write data, low 16 bits) starts a write frame, with all 64 bits driven, MSB first: 32 ones, 01, 01, PHY address, register number, 10, data.
- R3: A read starts only on a 0-to-1 change of bit 0 of word index 1 (command). Writing 1 while the bit is already 1 starts nothing. A read frame drives 32 ones, 01, 10, PHY address and register number, then releases MDIO for the remaining 18 bits.
- R4: Bit 0 of word index 5 (indication) reads 1 from the cycle after a command is accepted until the frame is over. The MDIO output enable is never high while this bit is 0.
- R5: Bit 2 of word index 5 (not-valid) is set when a read starts and stays set until the read data is available.
- R6: After a read, bits [15:0] of word index 4 (read data) hold the 16 bits that the PHY returned in the final 16 bit times, first bit in bit 15.
- R7: Bits [2:0] of word index 0 (configuration) select an MDC period of 8 × (code + 1) system clocks; after reset the code is 7.
- R8: MDIO output changes only on falling MDC edges, and input bits are sampled on rising MDC edges.
- R9: A write or read command that arrives while bit 0 of word index 5 is 1 is ignored: the current frame goes on unchanged and no further frame follows.
- R10: Writing 1 to bit 31 of word index 0 ends any frame. In the next cycle busy and the output enable are 0. The code in bits [2:0] is taken from the same write, and bit 31 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Directed frames use extreme fields. One has PHY address all ones and register zero with an alternating data pattern. The other is the reverse, which exposes swapped or misaligned fields and wrong opcodes. Read frames return asymmetric data such as 0x8001, so a bit-order reversal or an off-by-one sampling edge changes the result. Repeated command-bit writes and commands issued mid-frame separate edge detection from level detection, and an accepted command from an ignored one. Random operations at several divider codes, together with MDC period measurements at codes 0, 2 and 7, test the divider formula against the serializer timing.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam logic [2:0] IDX_CFG  = 3'd0;
   localparam logic [2:0] IDX_CMD  = 3'd1;
   localparam logic [2:0] IDX_ADR  = 3'd2;
   localparam logic [2:0] IDX_WDAT = 3'd3;
   localparam logic [2:0] IDX_RDAT = 3'd4;
   localparam logic [2:0] IDX_IND  = 3'd5;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int CODE_W   = 3,
   parameter int DIV_UNIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic              mdc,
   output logic              tick_rise,
   output logic              tick_fall
);
   localparam int CNT_W = $clog2(DIV_UNIT << CODE_W) + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;
   logic             at_end;

   assign half_m1   = CNT_W'((32'(code) + 32'd1) * DIV_UNIT - 32'd1);
   assign at_end    = (cnt >= half_m1);
   assign tick_rise = at_end & ~mdc;
   assign tick_fall = at_end & mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (at_end) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine #(
   parameter int PRE_LEN = 32,
   parameter bit SYNC_IN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_rise,
   input  logic        tick_fall,
   input  logic        mdio_i,
   input  logic        start,
   input  logic        is_read,
   input  logic [4:0]  phy,
   input  logic [4:0]  regn,
   input  logic [15:0] wdata,
   input  logic        abort,
   output logic        busy,
   output logic        nvalid,
   output logic [15:0] rdata,
   output logic        mdio_o,
   output logic        mdio_oe
);
   import mdio_pkg::*;

   localparam int FRAME    = PRE_LEN + 32;
   localparam int CW       = $clog2(FRAME + 1);
   localparam int DRV_LEN  = PRE_LEN + 14;
   localparam int SMP_FROM = PRE_LEN + 17;

   logic [FRAME-1:0] tx;
   logic [CW-1:0]    bitc;
   logic             rd_op;
   logic [15:0]      rx;
   logic             din;

   generate
      if (SYNC_IN) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], mdio_i};
         end
         assign din = sync_q[1];
      end else begin : g_direct
         assign din = mdio_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         nvalid  <= 1'b0;
         rdata   <= '0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
         tx      <= '0;
         bitc    <= '0;
         rd_op   <= 1'b0;
         rx      <= '0;
      end else if (abort) begin
         busy    <= 1'b0;
         mdio_oe <= 1'b0;
         bitc    <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         rd_op <= is_read;
         bitc  <= '0;
         tx    <= {{PRE_LEN{1'b1}}, 2'b01, (is_read ? OP_RD : OP_WR),
                   phy, regn, 2'b10, (is_read ? 16'h0000 : wdata)};
         if (is_read) nvalid <= 1'b1;
      end else if (busy) begin
         if (tick_fall) begin
            if (bitc == CW'(FRAME)) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
               if (rd_op) begin
                  rdata  <= rx;
                  nvalid <= 1'b0;
               end
            end else begin
               mdio_o  <= tx[FRAME-1];
               tx      <= {tx[FRAME-2:0], 1'b0};
               mdio_oe <= !rd_op || (bitc < CW'(DRV_LEN));
               bitc    <= bitc + 1'b1;
            end
         end
         if (tick_rise && rd_op && (bitc >= CW'(SMP_FROM)))
            rx <= {rx[14:0], din};
      end
   end

   a_r4_oe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> busy);
   a_r8_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_o != $past(mdio_o)) |-> $past(tick_fall));
   a_r4_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick_fall || abort));
   a_r5_nv_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nvalid) |-> $rose(busy));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int CODE_W   = 3,
   parameter int DIV_UNIT = 4,
   parameter int PRE_LEN  = 32,
   parameter bit SYNC_IN  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_idx,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe
);
   import mdio_pkg::*;

   generate
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
         $error("CODE_W must lie in 1..8");
      end
      if (DIV_UNIT < 3) begin : g_bad_div
         $error("DIV_UNIT must be at least 3");
      end
      if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..32");
      end
   endgenerate

   logic [CODE_W-1:0] cfg_code;
   logic              cmd_bit;
   logic [4:0]        adr_phy;
   logic [4:0]        adr_reg;
   logic [15:0]       wdat_q;
   logic              soft_rst, rd_start, wr_start;
   logic              tick_rise, tick_fall;
   logic              busy, nvalid;
   logic [15:0]       rdata;
   logic              unused_bits;

   assign unused_bits = ^{reg_wdata[30:16], reg_wdata[7:5], reg_wdata[15:13]};

   assign soft_rst = reg_we && (reg_idx == IDX_CFG) && reg_wdata[31];
   assign rd_start = reg_we && (reg_idx == IDX_CMD) && reg_wdata[0] && !cmd_bit;
   assign wr_start = reg_we && (reg_idx == IDX_WDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_code <= '1;
         cmd_bit  <= 1'b0;
         adr_phy  <= '0;
         adr_reg  <= '0;
         wdat_q   <= '0;
      end else if (reg_we) begin
         case (reg_idx)
            IDX_CFG:  cfg_code <= reg_wdata[CODE_W-1:0];
            IDX_CMD:  cmd_bit  <= reg_wdata[0];
            IDX_ADR: begin
               adr_phy <= reg_wdata[12:8];
               adr_reg <= reg_wdata[4:0];
            end
            IDX_WDAT: wdat_q   <= reg_wdata[15:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_idx)
         IDX_CFG:  reg_rdata = 32'(cfg_code);
         IDX_CMD:  reg_rdata = {31'd0, cmd_bit};
         IDX_ADR:  reg_rdata = {19'd0, adr_phy, 3'd0, adr_reg};
         IDX_WDAT: reg_rdata = {16'd0, wdat_q};
         IDX_RDAT: reg_rdata = {16'd0, rdata};
         IDX_IND:  reg_rdata = {29'd0, nvalid, 1'b0, busy};
         default:  reg_rdata = '0;
      endcase
   end

   mdio_clkgen #(.CODE_W(CODE_W), .DIV_UNIT(DIV_UNIT)) u_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .code      (cfg_code),
      .mdc       (mdc),
      .tick_rise (tick_rise),
      .tick_fall (tick_fall)
   );

   mdio_engine #(.PRE_LEN(PRE_LEN), .SYNC_IN(SYNC_IN)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_rise (tick_rise),
      .tick_fall (tick_fall),
      .mdio_i    (mdio_i),
      .start     (rd_start || wr_start),
      .is_read   (rd_start),
      .phy       (adr_phy),
      .regn      (adr_reg),
      .wdata     (reg_wdata[15:0]),
      .abort     (soft_rst),
      .busy      (busy),
      .nvalid    (nvalid),
      .rdata     (rdata),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe)
   );

   a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!busy && !mdio_oe));
   a_r9_start_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_start && !soft_rst) |=> busy);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_idx = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   mdio_master uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      summary();
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] val);
      @(negedge clk);
      reg_idx = idx;
      #1 val = reg_rdata;
   endtask

   function automatic logic [63:0] exp_bits(input bit isrd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (isrd ? 2'b10 : 2'b01), p, r, 2'b10, (isrd ? 16'h0 : d)};
   endfunction

   function automatic logic [63:0] exp_oe(input bit isrd);
      return isrd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
   endfunction

   task automatic wait_idle(input string req);
      logic [31:0] v;
      int k = 0;
      do begin
         rd(3'd5, v);
         k++;
      end while (v[0] && k < 20000);
      chk(!v[0], req, {32'd0, v}, 64'd0);
   endtask

   // Runs one frame. inject_at > 0 issues a second write at that bit;
   // abort_at > 0 aborts at that bit and returns.
   task automatic frame(input bit isrd, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d, input int inject_at, input int abort_at,
                        input string req);
      logic [63:0] go, ge, eb, eo;
      logic [31:0] v;
      go = '0; ge = '0;
      wr(3'd2, {19'd0, p, 3'd0, r});
      if (isrd) begin
         wr(3'd1, 32'd0);
         wr(3'd1, 32'd1);
      end else begin
         wr(3'd3, {16'hDEAD, d});
      end
      rd(3'd5, v);
      chk(v[0] == 1'b1, "R4 busy after start", {32'd0, v}, 64'd1);
      if (isrd) chk(v[2] == 1'b1, "R5 not-valid at read start", {32'd0, v}, 64'd5);
      do @(posedge mdc); while (!mdio_oe);
      go[63] = mdio_o; ge[63] = mdio_oe;
      for (int i = 1; i < 64; i++) begin
         if (isrd && i >= 48) begin
            @(negedge mdc);
            mdio_i = d[63-i];
         end
         @(posedge mdc);
         go[63-i] = mdio_o; ge[63-i] = mdio_oe;
         if (i == inject_at) wr(3'd3, {16'd0, ~d});
         if (i == abort_at) begin
            wr(3'd0, 32'h8000_0001);
            chk(!mdio_oe, "R10 oe off after abort", {63'd0, mdio_oe}, 64'd0);
            rd(3'd5, v);
            chk(v[0] == 1'b0, "R10 busy off after abort", {32'd0, v}, 64'd0);
            rd(3'd0, v);
            chk(v == 32'd1, "R10 code kept, bit31 reads 0", {32'd0, v}, 64'd1);
            return;
         end
      end
      eb = exp_bits(isrd, p, r, d);
      eo = exp_oe(isrd);
      chk(ge == eo, {req, " enable pattern"}, ge, eo);
      chk((go & eo) == (eb & eo), {req, " driven bits"}, go & eo, eb & eo);
      wait_idle({req, " R4 busy clears"});
      mdio_i = 1'b1;
      if (isrd) begin
         rd(3'd5, v);
         chk(v[2] == 1'b0, "R5 not-valid cleared", {32'd0, v}, 64'd0);
         rd(3'd4, v);
         chk(v == {16'd0, d}, "R6/R8 read data", {32'd0, v}, {48'd0, d});
      end
   endtask

   task automatic period(input int code);
      time t0, t1;
      wr(3'd0, code);
      @(posedge mdc); @(posedge mdc);
      t0 = $time;
      @(posedge mdc);
      t1 = $time;
      chk((t1 - t0) / 20 == 8 * (code + 1), "R7 MDC period", (t1 - t0) / 20, 8 * (code + 1));
   endtask

   initial begin
      logic [31:0] v;
      int seed;
      seed = $urandom(32'd4242);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      rd(3'd5, v); chk(v == 0, "R4 reset indication", {32'd0, v}, 0);
      rd(3'd0, v); chk(v == 7, "R7 reset code", {32'd0, v}, 7);
      rd(3'd4, v); chk(v == 0, "R6 reset read data", {32'd0, v}, 0);
      chk(!mdio_oe, "R4 reset oe", {63'd0, mdio_oe}, 0);

      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, v); chk(v == 32'h1F1F, "R1 address fields", {32'd0, v}, 64'h1F1F);

      period(7);
      period(0);
      period(2);

      wr(3'd0, 32'd7);
      frame(1'b0, 5'h1F, 5'h00, 16'hA55A, 0, 0, "R2 write max phy");
      frame(1'b1, 5'h00, 5'h1F, 16'h8001, 0, 0, "R3 read max reg");

      wr(3'd0, 32'd1);
      // R3: command bit already 1, rewriting 1 starts nothing
      wr(3'd1, 32'd1);
      repeat (40) @(negedge clk);
      rd(3'd5, v); chk(v[0] == 1'b0, "R3 no read without 0-to-1", {32'd0, v}, 0);
      chk(!mdio_oe, "R3 no frame driven", {63'd0, mdio_oe}, 0);

      // R9: write issued mid-frame is ignored
      frame(1'b0, 5'h0A, 5'h15, 16'h3C3C, 40, 0, "R9 ignored mid-frame write");
      repeat (200) @(negedge clk);
      rd(3'd5, v); chk(v[0] == 1'b0, "R9 no queued frame", {32'd0, v}, 0);
      chk(!mdio_oe, "R9 no queued drive", {63'd0, mdio_oe}, 0);

      // R10: abort mid-frame, then a clean frame
      frame(1'b0, 5'h11, 5'h02, 16'hFFFF, 0, 20, "R10 abort");
      repeat (100) @(negedge clk);
      chk(!mdio_oe, "R10 stays idle", {63'd0, mdio_oe}, 0);
      frame(1'b0, 5'h11, 5'h02, 16'h0001, 0, 0, "R10 recovery write");

      for (int k = 0; k < 6; k++) begin
         logic [31:0] rv;
         rv = $urandom;
         wr(3'd0, {29'd0, 3'(rv[1:0])});
         frame(rv[2], rv[7:3], rv[12:8], rv[31:16], 0, 0, "R2/R3 random frame");
      end
      summary();
   end
endmodule